// File: doc/BRIEF.md
# Indirect Register Window Controller

This block gives software a small register file through two bus offsets. A select register picks a target, and a data window at a second offset reads or writes that target 32 bits at a time. The targets are an identification register, a read-only version register, and a parameterised table of 64-bit redirection entries. Each table entry is reached as two 32-bit halves. A third offset takes end-of-interrupt writes and turns each one into a one-cycle broadcast pulse that carries the written vector. This pulse exists only when the block is built as version 0x20.

Delivery logic sits beside the block. It reads every entry through a flat output bus. It reports the two read-only status bits of an entry (remote-IRR and delivery-busy) through a status update port. It receives a per-index "entry changed" strobe, which it uses to clear its own storm counter for that pin.

There is no back-pressure. The block accepts one bus request in every cycle that `bus_valid` is high. Read data comes back exactly one cycle later, flagged by `bus_rvalid`. The status port and both output pulses are single-cycle and unhandshaked.

Entry layout (bit positions):
- Vector: 7:0.
- Delivery mode: 10:8.
- Destination mode: 11.
- Delivery-busy: 12, read-only.
- Polarity: 13.
- Remote-IRR: 14, read-only.
- Trigger: 15, where 1 means level and 0 means edge.
- Mask: 16.
- Destination index: 63:48.
- Bits 47:17 are reserved and always read zero.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset, the following hold:
  - The select register reads 0.
  - The ID reads 0.
  - Every table entry equals 0x0000_0000_0001_0000, so only the mask bit is set.
  - `bus_rvalid`, `upd_valid` and `eoi_valid` are low.
- R2: Offset 0x00 is the 8-bit select register. Reading it returns the written value in bits 7:0, with all other bits zero.
- R3: With select 0x00, a window read (offset 0x10) returns the 4-bit ID in bits 27:24 and zero elsewhere. A window write stores only `wdata[27:24]`.
- R4: With select 0x01, a window read returns the version code in bits 7:0 and NPINS−1 in bits 23:16. For the defaults this is 0x0017_0020.
- R5: Select values from 0x10 to 0x10+2·NPINS−1 reach table entry (select−0x10)>>1. An odd select reaches bits 63:32 and an even select reaches bits 31:0. No other entry is affected.
- R6: A window write to an entry does not change bits 12 and 14. Reserved bits 47:17 stay zero. All other bits take the written data.
- R7: After any window write to an entry, if its bit 15 is 0 (edge), bit 14 is 0.
- R8: A status update (`sts_valid`) sets bits 14 and 12 of entry `sts_idx` to `sts_remote_irr` and `sts_deliv_busy`, with no edge fix-up.
- R9: With VERSION 0x20, a write to offset 0x40 with `bus_size`=4 raises `eoi_valid` for one cycle in the next cycle, with `eoi_vector` = `wdata[7:0]`. Any other size is ignored, and every write there is ignored with VERSION 0x11.
- R10: A select outside ID, version and the table range reads 0 through the window and ignores window writes. The version register also ignores window writes.
- R11: One cycle after a window write to table entry k, `upd_valid` pulses with `upd_idx` = k. No pulse follows any other write.
- R12: A read request returns data with `bus_rvalid` one cycle later. Offsets other than 0x00 and 0x10 read 0.
- R13: VERSION may only be 0x11 or 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset (0x00 select, 0x10 window, 0x40 EOI) |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after request) |
| bus_rdata | output | 32 | Read data |
| sts_valid | input | 1 | Status update strobe from delivery logic |
| sts_idx | input | IDX_W | Entry the status update targets |
| sts_remote_irr | input | 1 | New remote-IRR value |
| sts_deliv_busy | input | 1 | New delivery-busy value |
| rte_flat | output | NPINS·64 | All entries, entry k at bits 64k+63:64k |
| upd_valid | output | 1 | Entry-changed strobe |
| upd_idx | output | IDX_W | Index of changed entry |
| eoi_valid | output | 1 | EOI broadcast pulse |
| eoi_vector | output | 8 | Vector carried by the EOI broadcast |

## Verification
The assertions assume a few things about the inputs:
- At most one bus request per cycle.
- `sts_idx` always below NPINS.
- All inputs low while reset is held.

Under those conditions, the `$past` comparisons in the entry and top-level checks see well-defined history. The bench honours these assumptions by driving every request and status update from tasks at the falling edge. Each task holds `valid` for exactly one cycle and uses indices that are always in range. It then samples every result at the following falling edge, after the single register stage.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ENTRY_W = 64;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h40;

  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_TBL = 8'h10;

  localparam int unsigned BIT_DBUSY = 12;
  localparam int unsigned BIT_RIRR  = 14;
  localparam int unsigned BIT_TRIG  = 15;
  localparam int unsigned BIT_MASK  = 16;

  localparam int unsigned ID_LSB  = 24;
  localparam int unsigned ID_W    = 4;
  localparam int unsigned MAXE_LSB = 16;

  localparam logic [ENTRY_W-1:0] RW_MASK  = 64'hFFFF_0000_0001_AFFF;
  localparam logic [ENTRY_W-1:0] RO_MASK  = 64'h0000_0000_0000_5000;
  localparam logic [ENTRY_W-1:0] RST_ENTRY = 64'h0000_0000_0001_0000;

  localparam logic [2:0] EOI_SIZE = 3'd4;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_TBL
  } tgt_e;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  localparam int unsigned IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       sel,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] idx,
  output logic             upper
);
  localparam int unsigned TBL_END = int'(SEL_TBL) + 2 * NPINS;

  always_comb begin
    int unsigned s;
    s     = int'(sel);
    tgt   = TGT_NONE;
    idx   = '0;
    upper = 1'b0;
    if (sel == SEL_ID) begin
      tgt = TGT_ID;
    end else if (sel == SEL_VER) begin
      tgt = TGT_VER;
    end else if (s >= int'(SEL_TBL) && s < TBL_END) begin
      tgt   = TGT_TBL;
      idx   = IDX_W'((s - int'(SEL_TBL)) >> 1);
      upper = sel[0];
    end
  end

  // R5
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_TBL) |-> (int'(idx) < NPINS));
endmodule

// File: rtl/regwin_entry.sv
module regwin_entry
  import regwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_upper,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               sts_en,
  input  logic               sts_rirr,
  input  logic               sts_dbusy,
  output logic [ENTRY_W-1:0] ent_q
);
  logic [ENTRY_W-1:0] merged;
  logic [ENTRY_W-1:0] ent_d;

  always_comb begin
    merged = ent_q;
    if (wr_upper) merged[63:32] = wr_data;
    else          merged[31:0]  = wr_data;

    ent_d = ent_q;
    if (wr_en) ent_d = (merged & RW_MASK) | (ent_q & RO_MASK);
    if (sts_en) begin
      ent_d[BIT_RIRR]  = sts_rirr;
      ent_d[BIT_DBUSY] = sts_dbusy;
    end
    if (wr_en && !ent_d[BIT_TRIG]) ent_d[BIT_RIRR] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ent_q <= RST_ENTRY;
    else        ent_q <= ent_d;
  end

  // R6
  ro_busy_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sts_en) |=> (ent_q[BIT_DBUSY] == $past(ent_q[BIT_DBUSY])));
  // R6
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_q[47:17] == '0);
  // R7
  edge_rirr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !(!ent_q[BIT_TRIG] && ent_q[BIT_RIRR]));
  // R8
  sts_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_en && !wr_en) |=> (ent_q[BIT_RIRR] == $past(sts_rirr)
                           && ent_q[BIT_DBUSY] == $past(sts_dbusy)));
endmodule

// File: rtl/regwin_rdmux.sv
module regwin_rdmux
  import regwin_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  parameter logic [7:0]  VERSION = 8'h20,
  localparam int unsigned IDX_W = $clog2(NPINS)
) (
  input  tgt_e                     tgt,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     upper,
  input  logic [ID_W-1:0]          id_val,
  input  logic [NPINS*ENTRY_W-1:0] tbl,
  output logic [WORD_W-1:0]        word
);
  localparam logic [7:0] MAXE = 8'(NPINS - 1);

  logic [ENTRY_W-1:0] ent_sel;

  always_comb begin
    ent_sel = tbl[int'(idx)*ENTRY_W +: ENTRY_W];
    word    = '0;
    unique case (tgt)
      TGT_ID:  word[ID_LSB +: ID_W] = id_val;
      TGT_VER: begin
        word[7:0]           = VERSION;
        word[MAXE_LSB +: 8] = MAXE;
      end
      TGT_TBL: word = upper ? ent_sel[63:32] : ent_sel[31:0];
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  parameter logic [7:0]  VERSION = 8'h20,
  localparam int unsigned IDX_W = $clog2(NPINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [7:0]               bus_addr,
  input  logic [2:0]               bus_size,
  input  logic [31:0]              bus_wdata,
  output logic                     bus_rvalid,
  output logic [31:0]              bus_rdata,
  input  logic                     sts_valid,
  input  logic [IDX_W-1:0]         sts_idx,
  input  logic                     sts_remote_irr,
  input  logic                     sts_deliv_busy,
  output logic [NPINS*64-1:0]      rte_flat,
  output logic                     upd_valid,
  output logic [IDX_W-1:0]         upd_idx,
  output logic                     eoi_valid,
  output logic [7:0]               eoi_vector
);
  localparam bit EOI_EN = (VERSION == 8'h20);

  // R13
  initial begin
    version_legal_chk: assert (VERSION == 8'h11 || VERSION == 8'h20);
  end

  logic [7:0]        sel_q;
  logic [ID_W-1:0]   id_q;
  tgt_e              dec_tgt;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_upper;
  logic [WORD_W-1:0] win_word;

  logic wr_req, rd_req, sel_wr, win_wr, tbl_wr, id_wr, eoi_wr;

  assign wr_req = bus_valid && bus_write;
  assign rd_req = bus_valid && !bus_write;
  assign sel_wr = wr_req && bus_addr == OFF_SEL;
  assign win_wr = wr_req && bus_addr == OFF_WIN;
  assign tbl_wr = win_wr && dec_tgt == TGT_TBL;
  assign id_wr  = win_wr && dec_tgt == TGT_ID;
  assign eoi_wr = EOI_EN && wr_req && bus_addr == OFF_EOI && bus_size == EOI_SIZE;

  regwin_decode #(.NPINS(NPINS)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel_q),
    .tgt   (dec_tgt),
    .idx   (dec_idx),
    .upper (dec_upper)
  );

  for (genvar k = 0; k < NPINS; k++) begin : g_ent
    logic ent_wr, ent_sts;
    assign ent_wr  = tbl_wr && int'(dec_idx) == k;
    assign ent_sts = sts_valid && int'(sts_idx) == k;
    regwin_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ent_wr),
      .wr_upper  (dec_upper),
      .wr_data   (bus_wdata),
      .sts_en    (ent_sts),
      .sts_rirr  (sts_remote_irr),
      .sts_dbusy (sts_deliv_busy),
      .ent_q     (rte_flat[k*64 +: 64])
    );
  end

  regwin_rdmux #(.NPINS(NPINS), .VERSION(VERSION)) u_rd (
    .tgt    (dec_tgt),
    .idx    (dec_idx),
    .upper  (dec_upper),
    .id_val (id_q),
    .tbl    (rte_flat),
    .word   (win_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q      <= '0;
      id_q       <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      upd_valid  <= 1'b0;
      upd_idx    <= '0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata[7:0];
      if (id_wr)  id_q  <= bus_wdata[ID_LSB +: ID_W];
      bus_rvalid <= rd_req;
      if (rd_req) begin
        unique case (bus_addr)
          OFF_SEL: bus_rdata <= {24'h0, sel_q};
          OFF_WIN: bus_rdata <= win_word;
          default: bus_rdata <= '0;
        endcase
      end
      upd_valid <= tbl_wr;
      if (tbl_wr) upd_idx <= dec_idx;
      eoi_valid <= eoi_wr;
      if (eoi_wr) eoi_vector <= bus_wdata[7:0];
    end
  end

  // R12
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  // R12
  rd_unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_addr != OFF_SEL && bus_addr != OFF_WIN) |=> bus_rdata == '0);
  // R10
  rd_none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_addr == OFF_WIN && dec_tgt == TGT_NONE) |=> bus_rdata == '0);
  // R11
  upd_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |=> (upd_valid && upd_idx == $past(dec_idx)));
  // R11
  upd_only_tbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(wr_req && bus_addr == OFF_WIN));
  // R9
  eoi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(wr_req && bus_addr == OFF_EOI && bus_size == EOI_SIZE));
  // R9
  eoi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> (eoi_valid && eoi_vector == $past(bus_wdata[7:0])));
  // R3
  id_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_wr |=> $stable(id_q));
endmodule

// File: tb/sim_regwin_ctrl.sv
module sim_regwin_ctrl;
  localparam int unsigned NPINS = 24;
  localparam int unsigned IDX_W = $clog2(NPINS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic sts_valid = 1'b0, sts_remote_irr = 1'b0, sts_deliv_busy = 1'b0;
  logic [IDX_W-1:0] sts_idx = '0;

  logic        rv0, rv1, uv0, uv1, ev0, ev1;
  logic [31:0] rd0, rd1;
  logic [IDX_W-1:0] ui0, ui1;
  logic [7:0]  evec0, evec1;
  logic [NPINS*64-1:0] flat0, flat1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] got, got1;
  logic s_uv, s_ev, s_ev1;
  logic [IDX_W-1:0] s_ui;
  logic [7:0] s_evec;

  always #4 clk = ~clk;

  regwin_ctrl #(.NPINS(NPINS), .VERSION(8'h20)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rvalid(rv0), .bus_rdata(rd0), .sts_valid(sts_valid), .sts_idx(sts_idx),
    .sts_remote_irr(sts_remote_irr), .sts_deliv_busy(sts_deliv_busy),
    .rte_flat(flat0), .upd_valid(uv0), .upd_idx(ui0), .eoi_valid(ev0),
    .eoi_vector(evec0));

  regwin_ctrl #(.NPINS(NPINS), .VERSION(8'h11)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rvalid(rv1), .bus_rdata(rd1), .sts_valid(sts_valid), .sts_idx(sts_idx),
    .sts_remote_irr(sts_remote_irr), .sts_deliv_busy(sts_deliv_busy),
    .rte_flat(flat1), .upd_valid(uv1), .upd_idx(ui1), .eoi_valid(ev1),
    .eoi_vector(evec1));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d, logic [2:0] sz = 3'd4);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    s_uv = uv0; s_ui = ui0; s_ev = ev0; s_evec = evec0; s_ev1 = ev1;
  endtask

  task automatic bus_rd(logic [7:0] a);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_size = 3'd4;
    @(negedge clk);
    bus_valid = 0;
    check("R12 rvalid", rv0, 1'b1);
    got = rd0; got1 = rd1;
  endtask

  task automatic sts_upd(int idx, logic ri, logic db);
    @(negedge clk);
    sts_valid = 1; sts_idx = IDX_W'(idx); sts_remote_irr = ri; sts_deliv_busy = db;
    @(negedge clk);
    sts_valid = 0;
  endtask

  task automatic win_rd(logic [7:0] s);
    bus_wr(8'h00, {24'h0, s});
    bus_rd(8'h10);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 rvalid", rv0, 0);
    check("R1 upd", uv0, 0);
    check("R1 eoi", ev0, 0);
    bus_rd(8'h00); check("R1 select", got, 0);
    win_rd(8'h00); check("R1 id", got, 0);
    win_rd(8'h10); check("R1 entry0 low", got, 32'h0001_0000);
    win_rd(8'h3F); check("R1 entry23 high", got, 0);
  endtask

  task automatic t_select();
    bus_wr(8'h00, 32'hFFFF_FF25);
    bus_rd(8'h00); check("R2 select readback", got, 32'h25);
  endtask

  task automatic t_id();
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    check("R11 no upd on id write", s_uv, 0);
    bus_rd(8'h10); check("R3 id field", got, 32'h0F00_0000);
  endtask

  task automatic t_version();
    win_rd(8'h01);
    check("R4 version v20", got, 32'h0017_0020);
    check("R13 version v11", got1, 32'h0017_0011);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10); check("R10 version write ignored", got, 32'h0017_0020);
  endtask

  task automatic t_table();
    bus_wr(8'h00, 32'h1A);
    bus_wr(8'h10, 32'h0000_80AB);
    check("R11 upd valid", s_uv, 1); check("R11 upd idx", s_ui, 5);
    bus_rd(8'h10); check("R5 entry5 low", got, 32'h0000_80AB);
    bus_wr(8'h00, 32'h1B);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10); check("R6 entry5 high reserved", got, 32'hFFFF_0000);
    win_rd(8'h18); check("R5 entry4 untouched", got, 32'h0001_0000);
    win_rd(8'h1C); check("R5 entry6 untouched", got, 32'h0001_0000);
  endtask

  task automatic t_ro();
    sts_upd(5, 1, 1);
    win_rd(8'h1A); check("R8 status set", got, 32'h0000_D0AB);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10); check("R6 ro kept level", got, 32'h0001_FFFF);
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h10); check("R7 edge clears rirr", got, 32'h0000_1000);
  endtask

  task automatic t_edge_sts();
    sts_upd(7, 1, 0);
    win_rd(8'h1E); check("R8 status on edge entry", got, 32'h0001_4000);
    bus_wr(8'h00, 32'h1F);
    bus_wr(8'h10, 32'h1200_0000);
    check("R11 upd idx 7", s_ui, 7);
    bus_rd(8'h10); check("R5 entry7 high", got, 32'h1200_0000);
    win_rd(8'h1E); check("R7 fixup after upper write", got, 32'h0001_0000);
  endtask

  task automatic t_eoi();
    bus_wr(8'h40, 32'h0000_1255);
    check("R9 eoi pulse", s_ev, 1); check("R9 eoi vector", s_evec, 8'h55);
    check("R9 v11 no eoi", s_ev1, 0);
    @(negedge clk); check("R9 single pulse", ev0, 0);
    bus_wr(8'h40, 32'h66, 3'd2);
    check("R9 size2 ignored", s_ev, 0);
    bus_wr(8'h44, 32'h77);
    check("R9 other offset", s_ev, 0);
    bus_rd(8'h44); check("R12 unmapped read", got, 0);
  endtask

  task automatic t_invalid();
    bus_wr(8'h00, 32'h40);
    bus_rd(8'h10); check("R10 read 0x40", got, 0);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    check("R11 no upd invalid", s_uv, 0);
    win_rd(8'h3F); check("R10 entry23 unchanged", got, 0);
    win_rd(8'h02); check("R10 read 0x02", got, 0);
    win_rd(8'h00); check("R10 id unchanged", got, 32'h0F00_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_select();
    t_id();
    t_version();
    t_table();
    t_ro();
    t_edge_sts();
    t_eoi();
    t_invalid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule